// File: doc/BRIEF.md
# Capture Trigger and Record Sequencer

This controller decides when a three-axis sampling pipeline captures data and where the result is filed. One of three start sources is active at a time: a command pulse from the register interface, an internal timer with a programmable period, or the rising edge of an external trigger pin. A started event collects a fixed number of accepted samples. Samples arrive on a valid strobe and are thinned by a selectable power-of-two decimation. The event then waits for the downstream transform datapath to report completion.

The event repeats this capture for a programmable number of averages. When the last one finishes, the record is filed into a 16-entry ring of record slots and the busy output drops. Triggers that arrive while an event is running are dropped, and a sticky overrun flag records them. A clear command rewinds the slot ring and clears the overrun flag.

Top module: `capture_sequencer`

## Requirements
- R1: `cfg_src` selects the start source: 0 is a `cmd_start` pulse, 1 is the internal timer, 2 is a rising edge of `ext_trig` and 3 selects no source. Events from the sources that are not selected have no effect.
- R2: A trigger from the selected source while idle raises `busy` on the next clock edge.
- R3: Each capture ends after `SAMPLES` accepted samples (default 512). A `proc_done` that arrives while samples are still being collected is ignored.
- R4: With `cfg_decim` = d, one out of every 2^d `smp_valid` strobes is accepted. The first strobe after the capture starts is always accepted.
- R5: An event runs 2^min(`cfg_avg`,8) captures, from 1 up to 256. Each capture ends with a `proc_done` accepted after collection. `cfg_avg` values above 8 give 256.
- R6: On the `proc_done` that closes the last capture, `busy` falls at the next edge. At that same edge `rec_done` pulses high for exactly one cycle, and `rec_slot` then shows the slot that was written.
- R7: Records are written to slots 0, 1, … 15 in turn and wrap from 15 back to 0. `rec_slot` changes only together with `rec_done`.
- R8: A trigger from the selected source while `busy` is high does not start or extend an event. It sets `overrun`, which stays set until cleared.
- R9: `cmd_clear` clears `overrun` and makes the next record go to slot 0. It does not abort a running event.
- R10: With `cfg_src` = 1 and a nonzero `cfg_period` of P, the timer fires on the P-th clock edge after it is enabled and every P edges after that. A period of 0 never fires.
- R11: An active-low `rst_n` returns the block to idle: `busy`, `rec_done` and `overrun` are low, and the next record goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | 2 | Trigger source select |
| cfg_avg | input | 4 | Log2 of the averaging count, saturating at 8 |
| cfg_decim | input | 2 | Log2 of the decimation ratio |
| cfg_period | input | 16 | Timer period in clocks, 0 disables |
| cmd_start | input | 1 | Command start pulse |
| cmd_clear | input | 1 | Ring and overrun clear pulse |
| ext_trig | input | 1 | External trigger, rising-edge sensitive, synchronous to clk |
| smp_valid | input | 1 | Sample strobe for all three axes |
| proc_done | input | 1 | Datapath completion pulse after a capture |
| busy | output | 1 | High while an event runs |
| rec_done | output | 1 | One-cycle pulse when a record is filed |
| rec_slot | output | 4 | Slot of the most recently filed record |
| overrun | output | 1 | Sticky flag for a trigger dropped while busy |

## Verification
For every capture, the bench feeds one strobe fewer than the decimation needs and then pulses a premature `proc_done`. A design that counts samples or decimates incorrectly accepts that pulse, and its capture count per record comes out wrong. Saturated averaging codes check that 256 captures are run rather than a wrapped or truncated count. Retriggers during an event, whether from a command or from the timer, must leave the slot sequence untouched and set the overrun flag. The slot ring is taken through its wrap from 15 to 0 and through a clear. An external level held high must not start a second event.

// File: rtl/capture_sequencer.sv
`timescale 1ns/1ps
module capture_sequencer #(
  parameter int SAMPLES     = 512,
  parameter int SLOTS       = 16,
  parameter int AVG_MAX_LOG = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_src,
  input  logic [3:0]               cfg_avg,
  input  logic [1:0]               cfg_decim,
  input  logic [15:0]              cfg_period,
  input  logic                     cmd_start,
  input  logic                     cmd_clear,
  input  logic                     ext_trig,
  input  logic                     smp_valid,
  input  logic                     proc_done,
  output logic                     busy,
  output logic                     rec_done,
  output logic [$clog2(SLOTS)-1:0] rec_slot,
  output logic                     overrun
);
  localparam int CW = $clog2(SAMPLES);
  localparam int SW = $clog2(SLOTS);
  localparam int AW = AVG_MAX_LOG;

  typedef enum logic [1:0] {S_IDLE, S_CAPT, S_WAIT} state_t;
  state_t state;

  logic          ext_q;
  logic [15:0]   tmr;
  logic [CW-1:0] smp_cnt;
  logic [AW-1:0] avg_cnt, avg_last;
  logic [1:0]    dec_l;
  logic [2:0]    dec_cnt;
  logic [SW-1:0] wr_ptr;

  wire       tmr_on   = (cfg_src == 2'd1) && (cfg_period != 16'd0);
  wire       tmr_fire = tmr_on && (tmr == cfg_period - 16'd1);
  wire       trig     = ((cfg_src == 2'd0) && cmd_start) || tmr_fire ||
                        ((cfg_src == 2'd2) && ext_trig && !ext_q);
  wire [3:0] avg_sat  = (cfg_avg > 4'(AVG_MAX_LOG)) ? 4'(AVG_MAX_LOG) : cfg_avg;
  wire [2:0] dec_mask = 3'((4'd1 << dec_l) - 4'd1);
  wire       take     = (state == S_CAPT) && smp_valid && (dec_cnt == 3'd0);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ext_q    <= 1'b0;
      tmr      <= '0;
      smp_cnt  <= '0;
      avg_cnt  <= '0;
      avg_last <= '0;
      dec_l    <= '0;
      dec_cnt  <= '0;
      wr_ptr   <= '0;
      rec_slot <= '0;
      rec_done <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      ext_q    <= ext_trig;
      rec_done <= 1'b0;
      tmr      <= (!tmr_on || tmr_fire) ? 16'd0 : tmr + 16'd1;
      if (trig && busy) overrun <= 1'b1;
      case (state)
        S_IDLE: if (trig) begin
          state    <= S_CAPT;
          smp_cnt  <= '0;
          dec_cnt  <= '0;
          avg_cnt  <= '0;
          dec_l    <= cfg_decim;
          avg_last <= {AW{1'b1}} >> (4'(AVG_MAX_LOG) - avg_sat);
        end
        S_CAPT: begin
          if (smp_valid) dec_cnt <= (dec_cnt == dec_mask) ? 3'd0 : dec_cnt + 3'd1;
          if (take) begin
            smp_cnt <= smp_cnt + 1'b1;
            if (smp_cnt == CW'(SAMPLES - 1)) state <= S_WAIT;
          end
        end
        S_WAIT: if (proc_done) begin
          if (avg_cnt == avg_last) begin
            state    <= S_IDLE;
            rec_done <= 1'b1;
            rec_slot <= wr_ptr;
            wr_ptr   <= wr_ptr + 1'b1;
          end else begin
            state   <= S_CAPT;
            avg_cnt <= avg_cnt + 1'b1;
            smp_cnt <= '0;
            dec_cnt <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (cmd_clear) begin
        overrun <= 1'b0;
        wr_ptr  <= '0;
      end
    end
  end
endmodule

// File: rtl/capture_sequencer_chk.sv
`timescale 1ns/1ps
module capture_sequencer_chk #(
  parameter int SLOTS = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               cfg_src,
  input logic                     cmd_start,
  input logic                     cmd_clear,
  input logic                     busy,
  input logic                     rec_done,
  input logic [$clog2(SLOTS)-1:0] rec_slot,
  input logic                     overrun
);
  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n) !busy && cmd_start && cfg_src == 2'd0 |=> busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rec_done |-> !busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rec_done |=> !rec_done); // R6
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> rec_done); // R6
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rec_done |-> $stable(rec_slot)); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) busy && cmd_start && cfg_src == 2'd0 && !cmd_clear |=> overrun); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun && !cmd_clear |=> overrun); // R8
  AST_CLR_OVR: assert property (@(posedge clk) disable iff (!rst_n) cmd_clear |=> !overrun); // R9
endmodule

bind capture_sequencer capture_sequencer_chk #(.SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cmd_start(cmd_start),
  .cmd_clear(cmd_clear), .busy(busy), .rec_done(rec_done),
  .rec_slot(rec_slot), .overrun(overrun)
);

// File: tb/capture_sequencer_tb_top.sv
`timescale 1ns/1ps
module capture_sequencer_tb_top;
  localparam int S = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_src = 2'd0, cfg_decim = 2'd0;
  logic [3:0] cfg_avg = 4'd0;
  logic [15:0] cfg_period = 16'd0;
  logic cmd_start = 0, cmd_clear = 0, ext_trig = 0, smp_valid = 0, proc_done = 0;
  logic busy, rec_done, overrun;
  logic [3:0] rec_slot;

  int checks = 0, errors = 0;
  logic [3:0] exp_slot = 4'd0;

  always #2.5 clk = ~clk;

  capture_sequencer #(.SAMPLES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_avg(cfg_avg),
    .cfg_decim(cfg_decim), .cfg_period(cfg_period), .cmd_start(cmd_start),
    .cmd_clear(cmd_clear), .ext_trig(ext_trig), .smp_valid(smp_valid),
    .proc_done(proc_done), .busy(busy), .rec_done(rec_done),
    .rec_slot(rec_slot), .overrun(overrun)
  );

  // {avg code, decim, gap between strobes, expected capture count}
  localparam logic [15:0] VEC [6] = '{
    {4'd0,  2'd0, 1'b0, 9'd1},
    {4'd1,  2'd1, 1'b1, 9'd2},
    {4'd3,  2'd2, 1'b0, 9'd8},
    {4'd2,  2'd3, 1'b1, 9'd4},
    {4'd8,  2'd0, 1'b0, 9'd256},
    {4'd12, 2'd0, 1'b1, 9'd256}
  };

  task automatic step; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1; step; smp_valid = 0;
      if (gap) step;
    end
  endtask

  task automatic pulse_done; proc_done = 1; step; proc_done = 0; endtask

  task automatic start_cmd; cmd_start = 1; step; cmd_start = 0; endtask

  // premature done must be ignored, then the last accepted sample and the real done
  task automatic one_capture(input int k, input bit gap);
    feed((S - 1) * k, gap);
    pulse_done;
    feed(1, gap);
    pulse_done;
  endtask

  task automatic run_record(input int k, input bit gap, output int n);
    n = 0;
    for (int c = 0; c < 300; c++) begin
      one_capture(k, gap);
      n++;
      if (!busy) break;
    end
  endtask

  initial begin
    #950000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step;
    rst_n = 1; step;
    // R11 reset state
    chk(!busy && !rec_done && !overrun && rec_slot == 0, "R11 reset state", busy, 0);

    for (int i = 0; i < 6; i++) begin
      cfg_avg = VEC[i][15:12]; cfg_decim = VEC[i][11:10];
      start_cmd;
      chk(busy, "R2 busy after command", busy, 1);
      run_record(1 << VEC[i][11:10], VEC[i][9], n);
      chk(n == int'(VEC[i][8:0]), "R3/R4/R5 captures per record", n, VEC[i][8:0]);
      chk(rec_done && !busy, "R6 completion pulse", rec_done, 1);
      chk(rec_slot == exp_slot, "R7 slot order", rec_slot, exp_slot);
      exp_slot++;
      step;
      chk(!rec_done, "R6 single-cycle pulse", rec_done, 0);
    end

    // R8 retrigger while busy
    cfg_avg = 0; cfg_decim = 0;
    start_cmd; start_cmd;
    chk(overrun, "R8 overrun set", overrun, 1);
    one_capture(1, 0);
    chk(!busy && rec_slot == exp_slot, "R8 single record filed", rec_slot, exp_slot);
    exp_slot++;
    repeat (5) step;
    chk(!busy && overrun, "R8 no extra event, flag sticky", busy, 0);

    // R9 clear
    cmd_clear = 1; step; cmd_clear = 0;
    chk(!overrun, "R9 overrun cleared", overrun, 0);
    start_cmd; one_capture(1, 0);
    chk(rec_slot == 0, "R9 ring rewound", rec_slot, 0);
    exp_slot = 4'd1;

    // R7 wrap through slot 15 to 0
    for (int r = 0; r < 16; r++) begin
      start_cmd; one_capture(1, 0);
      chk(rec_slot == exp_slot, "R7 slot ring", rec_slot, exp_slot);
      exp_slot++;
    end

    // R1 unselected sources, R10 zero period
    cfg_src = 2'd1; cfg_period = 16'd0;
    start_cmd; ext_trig = 1; step; ext_trig = 0;
    repeat (50) step;
    chk(!busy, "R1/R10 no start from command, pin or zero period", busy, 0);

    // R1 external edge, level held
    cfg_src = 2'd2;
    start_cmd; step;
    chk(!busy, "R1 command ignored in pin mode", busy, 0);
    ext_trig = 1; step;
    chk(busy, "R1 pin edge starts", busy, 1);
    one_capture(1, 0);
    exp_slot++;
    repeat (10) step;
    chk(!busy, "R1 held level does not retrigger", busy, 0);
    ext_trig = 0; step;

    // R10 timer period
    cfg_src = 2'd1; cfg_period = 16'd5;
    repeat (4) step;
    chk(!busy, "R10 timer before period", busy, 0);
    step;
    chk(busy, "R10 timer fires at period", busy, 1);
    repeat (5) step;
    chk(overrun, "R8/R10 timer fire while busy", overrun, 1);
    cfg_src = 2'd3;
    one_capture(1, 0);
    chk(!busy && rec_slot == exp_slot, "R10 timer record filed", rec_slot, exp_slot);

    // R11 reset during an event
    cfg_src = 2'd0;
    start_cmd;
    rst_n = 0; step; rst_n = 1; step;
    chk(!busy && !overrun && rec_slot == 0, "R11 reset mid-event", busy, 0);
    start_cmd; one_capture(1, 0);
    chk(rec_slot == 0, "R11 first slot after reset", rec_slot, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule